// File: doc/BRIEF.md
# Loop Replay Micro-op Buffer

This block sits between the decoders and the issue stage and watches the decoded micro-op stream. A micro-op flagged as a backward taken branch, with a tag naming its target, marks the start of a candidate loop. The block then records every micro-op that follows, up to and including the next backward taken branch with the same tag. If the recorded body is short enough, the block locks it. It then feeds the issue stage from its own store, over and over, while telling fetch and decode that they may idle.

A loop that turns out too long is dropped quietly. The micro-ops keep flowing straight from the decoders to issue as if the block were absent, with no flush and no lost cycle. The block leaves replay, or drops a partial recording, when the redirect input reports a loop exit or a misprediction.

Top module: `loop_replay_buf`

## Requirements
- R1: After reset the block is idle: `fetch_gate` and `dec_gate` are 0, `iss_valid` equals `dec_valid`, and `dec_ready` equals `iss_ready`.
- R2: In every state except replay, the issue port mirrors the decode port in the same cycle: `iss_valid` = `dec_valid`, `iss_uop` = `dec_uop`, and `dec_ready` = `iss_ready`. A transfer happens only when both valid and ready are 1.
- R3: In the idle state, an accepted micro-op with `br_back`=1 and no `redirect` starts a recording under its `br_tag`. The recording takes the micro-ops accepted after it, in order. It closes on, and includes, the next accepted micro-op that has `br_back`=1 and the same tag.
- R4: The store holds DEPTH (default 28) micro-ops. A closed loop of 1 to DEPTH-1 micro-ops enters replay. When the DEPTH-th micro-op is accepted without the loop having closed, the recording is dropped. From then until a `redirect`, the block stays in pass-through, never gates, and starts no new recording.
- R5: In replay, `iss_valid` is 1 and `iss_uop` presents the recorded micro-ops in recorded order, starting from the first one. After the last one comes the first again, with no idle cycle between them.
- R6: In replay, a cycle with `iss_ready`=0 holds `iss_uop` and does not advance the sequence.
- R7: In replay, `fetch_gate` and `dec_gate` are 1 and `dec_ready` is 0, so that decoded input is neither accepted nor forwarded.
- R8: When `redirect` is 1 during replay, `fetch_gate`, `dec_gate` and `iss_valid` are 0 in that same cycle. From the next cycle the block is idle and passes through.
- R9: When `redirect` is 1 during a recording, the recording is discarded and the block returns to idle. A `redirect` in the idle state keeps a `br_back` micro-op in that cycle from starting a recording.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decoded micro-op present |
| dec_ready | output | 1 | Block accepts the decoded micro-op |
| dec_uop | input | UOP_W | Decoded micro-op |
| br_back | input | 1 | Current micro-op is a backward taken branch |
| br_tag | input | TAG_W | Target tag of that branch |
| redirect | input | 1 | Loop exit or misprediction redirect |
| iss_valid | output | 1 | Micro-op offered to issue |
| iss_ready | input | 1 | Issue stage takes the micro-op |
| iss_uop | output | UOP_W | Micro-op to issue |
| fetch_gate | output | 1 | Fetch may idle |
| dec_gate | output | 1 | Decoders may idle |

## Verification
The bench sweeps every loop length from 1 to DEPTH+2 and checks both sides of the size limit. A design with an off-by-one there would either gate on a 28-entry loop or turn away a 27-entry one. During replay, issue readiness follows an irregular pattern. A bubble at the wrap, or a pointer that advances under backpressure, therefore shows up as a wrong micro-op at a known cycle. Redirects are aimed at the replay state, at a recording in progress, and at an idle-state loop start. A late gate release, or a stale partial recording, would then show up as gating or a wrong replayed micro-op.

// File: rtl/lrb_pkg.sv
package lrb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CAPTURE = 2'd1,
    ST_REPLAY  = 2'd2,
    ST_ABORT   = 2'd3
  } lrb_state_e;

  // Next read position in a loop of 'len' entries, wrapping to zero.
  function automatic int unsigned wrap_next(int unsigned ptr, int unsigned len);
    return (ptr + 1 >= len) ? 0 : ptr + 1;
  endfunction

  // A loop of 'len' micro-ops may be locked only if it is shorter than the store.
  function automatic bit loop_fits(int unsigned len, int unsigned depth);
    return len < depth;
  endfunction

endpackage

// File: rtl/lrb_store.sv
module lrb_store #(
  parameter int DEPTH = 28,
  parameter int UOP_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [UOP_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [UOP_W-1:0] rd_data
);

  logic [UOP_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];

  // R4: the recording never writes beyond the store
  assert_wr_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_idx) < DEPTH));

endmodule

// File: rtl/lrb_ctrl.sv
module lrb_ctrl
  import lrb_pkg::*;
#(
  parameter int DEPTH = 28,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_in,
  input  logic             br_back,
  input  logic [TAG_W-1:0] br_tag,
  input  logic             redirect,
  input  logic             iss_ready,
  output lrb_state_e       st,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] rd_ptr
);

  logic [CNT_W-1:0] cap_cnt;
  logic [CNT_W-1:0] loop_len;
  logic [TAG_W-1:0] lock_tag;

  // Named internal events
  logic start_ev, store_ev, close_ev, overflow_ev, adv_ev, wrap_ev;
  logic len_ok;

  assign len_ok      = loop_fits(32'(cap_cnt) + 1, DEPTH);
  assign start_ev    = (st == ST_IDLE) && xfer_in && br_back && !redirect;
  assign store_ev    = (st == ST_CAPTURE) && xfer_in && !redirect && len_ok;
  assign overflow_ev = (st == ST_CAPTURE) && xfer_in && !redirect && !len_ok;
  assign close_ev    = store_ev && br_back && (br_tag == lock_tag);
  assign adv_ev      = (st == ST_REPLAY) && iss_ready && !redirect;
  assign wrap_ev     = adv_ev && (32'(rd_ptr) + 1 == 32'(loop_len));

  assign wr_en  = store_ev;
  assign wr_idx = cap_cnt[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cap_cnt  <= '0;
      loop_len <= '0;
      lock_tag <= '0;
      rd_ptr   <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (start_ev) begin
            st       <= ST_CAPTURE;
            cap_cnt  <= '0;
            lock_tag <= br_tag;
          end
        end
        ST_CAPTURE: begin
          if (redirect) begin
            st <= ST_IDLE;
          end else if (overflow_ev) begin
            st <= ST_ABORT;
          end else if (close_ev) begin
            st       <= ST_REPLAY;
            loop_len <= cap_cnt + 1'b1;
            rd_ptr   <= '0;
          end else if (store_ev) begin
            cap_cnt <= cap_cnt + 1'b1;
          end
        end
        ST_REPLAY: begin
          if (redirect) begin
            st <= ST_IDLE;
          end else if (adv_ev) begin
            rd_ptr <= IDX_W'(wrap_next(32'(rd_ptr), 32'(loop_len)));
          end
        end
        ST_ABORT: begin
          if (redirect) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4: a recording in progress never holds DEPTH or more entries
  assert_cap_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CAPTURE) |-> (32'(cap_cnt) < DEPTH));

  // R5: the read position stays inside the locked loop
  assert_ptr_in_loop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REPLAY) |-> (rd_ptr < loop_len[IDX_W-1:0] || 32'(loop_len) == DEPTH));

  // R5: wrapping lands on entry zero in the very next cycle
  assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> (st == ST_REPLAY && rd_ptr == '0));

  // R6: no advance while issue holds off
  assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REPLAY && !iss_ready && !redirect) |=> (st == ST_REPLAY && $stable(rd_ptr)));

  // R8/R9: a redirect ends both replay and recording
  assert_redirect_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && (st == ST_REPLAY || st == ST_CAPTURE)) |=> (st == ST_IDLE));

endmodule

// File: rtl/loop_replay_buf.sv
module loop_replay_buf
  import lrb_pkg::*;
#(
  parameter int DEPTH = 28,
  parameter int UOP_W = 32,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  output logic             dec_ready,
  input  logic [UOP_W-1:0] dec_uop,
  input  logic             br_back,
  input  logic [TAG_W-1:0] br_tag,
  input  logic             redirect,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic [UOP_W-1:0] iss_uop,
  output logic             fetch_gate,
  output logic             dec_gate
);

  localparam int IDX_W = $clog2(DEPTH);

  lrb_state_e       st;
  logic             xfer_in;
  logic             in_replay;
  logic             replay_live;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_ptr;
  logic [UOP_W-1:0] rd_data;

  assign in_replay   = (st == ST_REPLAY);
  assign replay_live = in_replay && !redirect;

  assign dec_ready  = in_replay ? 1'b0 : iss_ready;
  assign iss_valid  = in_replay ? replay_live : dec_valid;
  assign iss_uop    = in_replay ? rd_data : dec_uop;
  assign fetch_gate = replay_live;
  assign dec_gate   = replay_live;
  assign xfer_in    = dec_valid && dec_ready;

  lrb_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_in   (xfer_in),
    .br_back   (br_back),
    .br_tag    (br_tag),
    .redirect  (redirect),
    .iss_ready (iss_ready),
    .st        (st),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .rd_ptr    (rd_ptr)
  );

  lrb_store #(.DEPTH(DEPTH), .UOP_W(UOP_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (dec_uop),
    .rd_idx  (rd_ptr),
    .rd_data (rd_data)
  );

  // R7: while fetch is gated the decode side is held off and issue is fed
  assert_gate_blocks_decode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_gate |-> (!dec_ready && iss_valid && dec_gate));

  // R8: gating is released in the cycle of the redirect
  assert_redirect_ungates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (!fetch_gate && !dec_gate));

  // R4: nothing is written unless a micro-op was actually accepted
  assert_write_needs_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> xfer_in);

endmodule

// File: tb/loop_replay_buf_test.sv
`timescale 1ns/1ps
module loop_replay_buf_test;

  localparam int DEPTH = 28;
  localparam int UOP_W = 32;
  localparam int TAG_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             dec_valid = 1'b0;
  logic             dec_ready;
  logic [UOP_W-1:0] dec_uop = '0;
  logic             br_back = 1'b0;
  logic [TAG_W-1:0] br_tag = '0;
  logic             redirect = 1'b0;
  logic             iss_valid;
  logic             iss_ready = 1'b1;
  logic [UOP_W-1:0] iss_uop;
  logic             fetch_gate;
  logic             dec_gate;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  loop_replay_buf #(.DEPTH(DEPTH), .UOP_W(UOP_W), .TAG_W(TAG_W)) uut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_uop(dec_uop), .br_back(br_back), .br_tag(br_tag), .redirect(redirect),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_uop(iss_uop),
    .fetch_gate(fetch_gate), .dec_gate(dec_gate)
  );

  function automatic logic [31:0] code(int l, int i);
    return 32'hC000_0000 | (32'(l) << 8) | 32'(i);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic flush();
    dec_valid = 0; br_back = 0; redirect = 1; iss_ready = 1;
    tick();
    redirect = 0;
  endtask

  // Pass-through checks used in every non-replay cycle
  task automatic chk_pass(string req);
    settle();
    chk(iss_valid == dec_valid, req, 32'(iss_valid), 32'(dec_valid));
    chk(dec_ready == iss_ready, req, 32'(dec_ready), 32'(iss_ready));
    if (dec_valid) chk(iss_uop == dec_uop, req, iss_uop, dec_uop);
    chk(!fetch_gate && !dec_gate, req, 32'(fetch_gate), 32'b0);
  endtask

  task automatic send(logic [31:0] u, bit bb, logic [7:0] t, string req);
    dec_valid = 1; dec_uop = u; br_back = bb; br_tag = t;
    chk_pass(req);
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R1: reset state
    settle();
    chk(!fetch_gate && !dec_gate, "R1", 32'(fetch_gate), 32'b0);
    chk(iss_valid == 1'b0, "R1", 32'(iss_valid), 32'b0);
    chk(dec_ready == 1'b1, "R1", 32'(dec_ready), 32'b1);
    rst_n = 1;
    tick();
    chk_pass("R1");

    // Sweep loop lengths across the DEPTH boundary (R3, R4, R5, R6, R7, R8)
    for (int l = 1; l <= DEPTH + 2; l++) begin
      logic [7:0] t;
      t = 8'(8'h40 + l);
      flush();
      send(code(l, 99), 1'b1, t, "R3");
      for (int i = 0; i < l; i++) begin
        if (i == 1) begin
          dec_valid = 1; dec_uop = code(l, i); br_back = (i == l - 1); br_tag = t;
          iss_ready = 0;
          chk_pass("R2");
          tick();
          iss_ready = 1;
        end
        send(code(l, i), (i == l - 1), t, "R3");
      end
      dec_valid = 0; br_back = 0;
      if (l <= DEPTH - 1) begin
        int idx;
        idx = 0;
        for (int c = 0; c < 3 * l + 4; c++) begin
          bit rdy;
          rdy = ((c * 7 + l) % 5) != 0;
          iss_ready = rdy;
          dec_valid = 1; dec_uop = 32'hDEAD_0000 | 32'(c);
          settle();
          chk(fetch_gate && dec_gate, "R7", 32'(fetch_gate), 32'b1);
          chk(!dec_ready, "R7", 32'(dec_ready), 32'b0);
          chk(iss_valid, "R5", 32'(iss_valid), 32'b1);
          chk(iss_uop == code(l, idx), (c > 0) ? "R6" : "R5", iss_uop, code(l, idx));
          tick();
          if (rdy) idx = (idx + 1) % l;
        end
        dec_valid = 0; redirect = 1; iss_ready = 1;
        settle();
        chk(!fetch_gate && !dec_gate, "R8", 32'(fetch_gate), 32'b0);
        chk(!iss_valid, "R8", 32'(iss_valid), 32'b0);
        tick();
        redirect = 0;
        send(32'h5A5A_0000 | 32'(l), 1'b0, 8'h00, "R8");
      end else begin
        // R4: oversize loop falls back; the next pass is not captured either
        chk_pass("R4");
        for (int i = 0; i < l; i++) send(code(l, i + 50), (i == l - 1), t, "R4");
        dec_valid = 0;
        chk_pass("R4");
        tick();
        chk_pass("R4");
      end
    end

    // R9: redirect in the middle of a recording
    flush();
    send(32'hAAAA_0000, 1'b1, 8'h22, "R9");
    for (int i = 0; i < 4; i++) send(32'hAAAA_0010 + 32'(i), 1'b0, 8'h22, "R9");
    redirect = 1;
    send(32'hAAAA_0020, 1'b1, 8'h22, "R9");
    redirect = 0; dec_valid = 0; br_back = 0;
    chk_pass("R9");
    tick();
    chk_pass("R9");
    // A fresh recording must contain only the new micro-op
    send(32'hBBBB_0001, 1'b1, 8'h22, "R9");
    send(32'hBBBB_0002, 1'b1, 8'h22, "R9");
    dec_valid = 0; br_back = 0;
    settle();
    chk(fetch_gate, "R9", 32'(fetch_gate), 32'b1);
    chk(iss_uop == 32'hBBBB_0002, "R9", iss_uop, 32'hBBBB_0002);
    tick();
    settle();
    chk(iss_uop == 32'hBBBB_0002, "R5", iss_uop, 32'hBBBB_0002);
    tick();

    // R9: redirect in idle blocks a loop start in the same cycle
    flush();
    redirect = 1;
    dec_valid = 1; dec_uop = 32'hCCCC_0001; br_back = 1; br_tag = 8'h33;
    tick();
    redirect = 0;
    send(32'hCCCC_0002, 1'b1, 8'h33, "R9");
    dec_valid = 0; br_back = 0;
    chk_pass("R9");
    tick();
    chk_pass("R9");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule